// File: doc/BRIEF.md
# Crossbar Address-Phase Router

This block steers the address phase of a small two-initiator, five-target interconnect. Each initiator presents a valid flag and an address. A decoder for each initiator compares the address with a table of target windows. Each window has a base and a mask, and the table is set by parameters. A hit produces a request to one target. A miss starts a decode-error response back to that initiator, and no target sees the request.

Each target has an arbiter that picks one requester. If both initiators want the same target, a rotating pointer decides which one wins. If they want different targets, both proceed in the same cycle. A grant is combinational with its request. The arbiter locks the grant while the target holds off acceptance. An accepted transfer (valid and ready both high) moves that target's pointer past the winner, so the loser is served next.

Each target arbiter has two states:
- **Idle**: the grant follows the pointer search. Idle→Locked when a grant is issued but the target's ready is low. Idle→Idle otherwise.
- **Locked**: the previous owner keeps the grant while it still requests. Locked→Idle when the target accepts, or when the owner withdraws and nobody new is left waiting. Locked→Locked while acceptance is still pending.

Each initiator's error responder also has two states:
- **Quiet**: Quiet→Respond when a valid request misses every window.
- **Respond**: raises the error flag for that cycle. Respond→Quiet always.

Top module: `xbar_addr_route`

## Requirements
- R1: Target window i (bits i*32 upward in the base and mask parameters) matches when (address & mask_i) == (base_i & mask_i). A matching valid request drives s_valid of that target high in the same cycle, with no other target selected by that initiator.
- R2: When several windows match one address, the window with the lowest index takes it.
- R3: A valid request that matches no window selects no target. m_decerr of that initiator is high in the cycle after the first cycle of such a request and low again one cycle later.
- R4: Two initiators requesting different targets are both granted and both accepted in the same cycle.
- R5: Each target's grant vector s_gnt (bit i*2+m means initiator m owns target i) is one-hot or zero, and it only ever names a requesting initiator.
- R6: After a transfer on a target completes, the other initiator wins that target's next contention.
- R7: Once an initiator is granted and the target's ready is low, it keeps the grant while it keeps requesting, even if the pointer would favour the other initiator.
- R8: m_ready of an initiator is high exactly when it holds a grant on a target whose s_ready is high.
- R9: While reset is held and no initiator requests, there are no grants, ready or error flags. After reset, each target's pointer favours initiator 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | NM | Request valid, one bit per initiator (0 = processor data, 1 = DMA) |
| m_addr | input | NM*AW | Request address, initiator m at bits m*AW upward |
| m_ready | output | NM | Request accepted by its target this cycle |
| m_decerr | output | NM | Decode-error response, one cycle |
| s_ready | input | NS | Target accepts its current request |
| s_valid | output | NS | Target selected this cycle |
| s_gnt | output | NS*NM | One-hot owner per target, target i at bits i*NM upward |
| s_addr | output | NS*AW | Address routed to each target |

## Verification
The hardest state to reach is a locked grant held by the initiator that the pointer does not favour. With the pointer at initiator 0, the stimulus first lets only initiator 1 request while the target's ready is low, so initiator 1 locks the grant. Initiator 0 then joins, and the grant must stay with initiator 1. The bench overrides the window table so that a small window at index 0 sits inside a larger window at index 1, and it sweeps addresses across the inside, the outside and the edges of that alias.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int DEF_NM = 2;
    localparam int DEF_NS = 5;
    localparam int DEF_AW = 32;

    // window 0 in the least significant word
    localparam logic [DEF_NS*DEF_AW-1:0] DEF_BASE = {
        32'h0000_0000, 32'h2000_0000, 32'h4C00_0000, 32'h5000_0000, 32'h6000_0000
    };
    localparam logic [DEF_NS*DEF_AW-1:0] DEF_MASK = {
        32'hFFFF_0000, 32'hFFFC_0000, 32'hFC00_0000, 32'hFFFF_F000, 32'hFFFF_F000
    };

    typedef enum logic {ARB_IDLE, ARB_LOCK} arb_state_e;
    typedef enum logic {ERR_QUIET, ERR_RESP} err_state_e;

endpackage

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode
    import xbar_pkg::*;
#(
    parameter int NS = DEF_NS,
    parameter int AW = DEF_AW,
    parameter logic [NS*AW-1:0] BASE = DEF_BASE,
    parameter logic [NS*AW-1:0] MASK = DEF_MASK
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o,
    output logic [NS-1:0] sel_o
);

    // scan from the highest index down so the lowest matching index is kept
    always_comb begin
        sel_o = '0;
        hit_o = 1'b0;
        for (int i = NS - 1; i >= 0; i--) begin
            if ((addr_i & MASK[i*AW +: AW]) == (BASE[i*AW +: AW] & MASK[i*AW +: AW])) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
                hit_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/xbar_decerr_resp.sv
module xbar_decerr_resp
    import xbar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_i,
    output logic err_o
);

    err_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ERR_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d  = ERR_QUIET;
        err_o = 1'b0;
        unique case (st_q)
            ERR_QUIET: st_d = miss_i ? ERR_RESP : ERR_QUIET;
            ERR_RESP:  begin
                err_o = 1'b1;
                st_d  = ERR_QUIET;
            end
            default: st_d = ERR_QUIET;
        endcase
    end

endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb
    import xbar_pkg::*;
#(
    parameter int NM = DEF_NM
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NM-1:0]                      req_i,
    input  logic                               ready_i,
    output logic [NM-1:0]                      gnt_o,
    output logic [((NM > 1) ? $clog2(NM) : 1)-1:0] owner_o
);

    localparam int MW = (NM > 1) ? $clog2(NM) : 1;

    arb_state_e     st_q, st_d;
    logic [MW-1:0]  rr_q, own_q, pick, cur;
    logic           found, take;

    // rotating search starting at the pointer
    always_comb begin
        found = 1'b0;
        pick  = rr_q;
        for (int k = 0; k < NM; k++) begin
            if (!found && req_i[MW'((int'(rr_q) + k) % NM)]) begin
                found = 1'b1;
                pick  = MW'((int'(rr_q) + k) % NM);
            end
        end
    end

    always_comb begin
        take = 1'b0;
        cur  = rr_q;
        unique case (st_q)
            ARB_IDLE: begin
                take = found;
                cur  = pick;
            end
            ARB_LOCK: begin
                if (req_i[own_q]) begin
                    take = 1'b1;
                    cur  = own_q;
                end else begin
                    take = found;
                    cur  = pick;
                end
            end
            default: ;
        endcase
        st_d  = (take && !ready_i) ? ARB_LOCK : ARB_IDLE;
        gnt_o = '0;
        if (take) gnt_o[cur] = 1'b1;
        owner_o = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ARB_IDLE;
            rr_q  <= '0;
            own_q <= '0;
        end else begin
            st_q <= st_d;
            if (take && !ready_i) own_q <= cur;
            if (take && ready_i)  rr_q  <= MW'((int'(cur) + 1) % NM);
        end
    end

    assert_gnt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_gnt_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> ((gnt_o & req_i) != '0));

    assert_gnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && !ready_i) |=>
        ((($past(gnt_o) & req_i) == '0) || (gnt_o == $past(gnt_o))));

endmodule

// File: rtl/xbar_addr_route.sv
module xbar_addr_route
    import xbar_pkg::*;
#(
    parameter int NM = DEF_NM,
    parameter int NS = DEF_NS,
    parameter int AW = DEF_AW,
    parameter logic [NS*AW-1:0] SLV_BASE = DEF_BASE,
    parameter logic [NS*AW-1:0] SLV_MASK = DEF_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    m_valid,
    input  logic [NM*AW-1:0] m_addr,
    output logic [NM-1:0]    m_ready,
    output logic [NM-1:0]    m_decerr,
    input  logic [NS-1:0]    s_ready,
    output logic [NS-1:0]    s_valid,
    output logic [NS*NM-1:0] s_gnt,
    output logic [NS*AW-1:0] s_addr
);

    localparam int MW = (NM > 1) ? $clog2(NM) : 1;

    logic [NM-1:0] hit;
    logic [NS-1:0] sel_m  [NM];
    logic [NM-1:0] req_s  [NS];
    logic [NM-1:0] gnt_s  [NS];
    logic [MW-1:0] own_s  [NS];
    logic [NM-1:0] gnt_to_m;

    for (genvar m = 0; m < NM; m++) begin : g_init
        xbar_addr_decode #(.NS(NS), .AW(AW), .BASE(SLV_BASE), .MASK(SLV_MASK)) u_dec (
            .addr_i (m_addr[m*AW +: AW]),
            .hit_o  (hit[m]),
            .sel_o  (sel_m[m])
        );
        xbar_decerr_resp u_err (
            .clk    (clk),
            .rst_n  (rst_n),
            .miss_i (m_valid[m] && !hit[m]),
            .err_o  (m_decerr[m])
        );

        assert_decerr_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[m] && !hit[m] && !m_decerr[m]) |=> m_decerr[m]);

        assert_decerr_nosel_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (m_valid[m] && !hit[m]) |-> !gnt_to_m[m]);

        assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
            m_ready[m] |-> m_valid[m]);
    end

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            for (int m = 0; m < NM; m++) begin
                req_s[s][m] = m_valid[m] & sel_m[m][s];
            end
        end
    end

    for (genvar s = 0; s < NS; s++) begin : g_targ
        xbar_slave_arb #(.NM(NM)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_s[s]),
            .ready_i (s_ready[s]),
            .gnt_o   (gnt_s[s]),
            .owner_o (own_s[s])
        );
        assign s_gnt[s*NM +: NM] = gnt_s[s];
        assign s_valid[s]        = |gnt_s[s];

        assert_no_idle_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_s[s] != '0) |-> s_valid[s]);
    end

    always_comb begin
        m_ready  = '0;
        gnt_to_m = '0;
        for (int s = 0; s < NS; s++) begin
            s_addr[s*AW +: AW] = m_addr[int'(own_s[s])*AW +: AW];
            for (int m = 0; m < NM; m++) begin
                if (gnt_s[s][m]) begin
                    gnt_to_m[m] = 1'b1;
                    if (s_ready[s]) m_ready[m] = 1'b1;
                end
            end
        end
    end

endmodule

// File: tb/sim_xbar_addr_route.sv
`timescale 1ns/1ps
module sim_xbar_addr_route;

    localparam int NM = 2;
    localparam int NS = 5;
    localparam int AW = 32;
    localparam int NV = 16;

    // window 0 is an alias inside the larger window 1
    localparam logic [NS*AW-1:0] TB_BASE = {
        32'h0000_0000, 32'h2000_0000, 32'h4C00_0000, 32'h5000_0000, 32'h5000_1000
    };
    localparam logic [NS*AW-1:0] TB_MASK = {
        32'hFFFF_0000, 32'hFFFC_0000, 32'hFC00_0000, 32'hF000_0000, 32'hFFFF_F000
    };

    // expected target index, NS means unmapped
    localparam logic [31:0] VADDR [NV] = '{
        32'h5000_1004, 32'h5000_0000, 32'h5FFF_FFFC, 32'h5000_2000,
        32'h4C00_0000, 32'h4FFF_FFFF, 32'h2000_0000, 32'h2003_FFFC,
        32'h2004_0000, 32'h0000_0000, 32'h0000_FFFF, 32'h0001_0000,
        32'h6000_0000, 32'h8000_0000, 32'h4BFF_FFFF, 32'h5000_1FFF
    };
    localparam int VEXP [NV] = '{0, 1, 1, 1, 2, 2, 3, 3, 5, 4, 4, 5, 5, 5, 5, 0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NM-1:0]    m_valid = '0;
    logic [NM*AW-1:0] m_addr = '0;
    logic [NM-1:0]    m_ready;
    logic [NM-1:0]    m_decerr;
    logic [NS-1:0]    s_ready = '0;
    logic [NS-1:0]    s_valid;
    logic [NS*NM-1:0] s_gnt;
    logic [NS*AW-1:0] s_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xbar_addr_route #(.NM(NM), .NS(NS), .AW(AW), .SLV_BASE(TB_BASE), .SLV_MASK(TB_MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_addr(m_addr),
        .m_ready(m_ready), .m_decerr(m_decerr), .s_ready(s_ready),
        .s_valid(s_valid), .s_gnt(s_gnt), .s_addr(s_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; m_valid = '0; s_ready = '0;
        repeat (2) @(negedge clk);
        #5;
        chk(s_valid == '0 && s_gnt == '0, "R9 reset grants", 64'(s_gnt), 64'h0);
        chk(m_ready == '0 && m_decerr == '0, "R9 reset flags", 64'({m_ready, m_decerr}), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();

        // address sweep over the window table
        for (int i = 0; i < NV; i++) begin
            int m;
            int e;
            m = i % NM;
            e = VEXP[i];
            @(negedge clk);
            m_valid = '0;
            m_valid[m] = 1'b1;
            m_addr[m*AW +: AW] = VADDR[i];
            s_ready = '1;
            #5;
            if (e < NS) begin
                chk(s_valid == NS'(1 << e), (e == 0) ? "R2 alias select" : "R1 window select",
                    64'(s_valid), 64'(1 << e));
                chk(s_gnt[e*NM +: NM] == NM'(1 << m), "R1 owner", 64'(s_gnt), 64'(1 << (e*NM + m)));
                chk(m_ready == NM'(1 << m), "R8 accept", 64'(m_ready), 64'(1 << m));
                @(negedge clk);
                m_valid = '0;
            end else begin
                chk(s_valid == '0, "R3 no target", 64'(s_valid), 64'h0);
                @(negedge clk);
                chk(m_decerr == NM'(1 << m), "R3 error raised", 64'(m_decerr), 64'(1 << m));
                m_valid = '0;
                @(negedge clk);
                chk(m_decerr == '0, "R3 error drops", 64'(m_decerr), 64'h0);
            end
        end

        do_reset();

        // contention on target 3 with ready low
        @(negedge clk);
        m_addr = {32'h2000_0020, 32'h2000_0010};
        m_valid = 2'b11;
        s_ready = '0;
        #5;
        chk(s_gnt[3*NM +: NM] == 2'b01, "R9 pointer favours initiator 0", 64'(s_gnt[3*NM +: NM]), 64'h1);
        chk(m_ready == '0, "R8 no accept while ready low", 64'(m_ready), 64'h0);
        @(negedge clk);
        #5;
        chk(s_gnt[3*NM +: NM] == 2'b01, "R7 lock holds", 64'(s_gnt[3*NM +: NM]), 64'h1);
        s_ready[3] = 1'b1;
        #1;
        chk(m_ready == 2'b01, "R8 accept on ready", 64'(m_ready), 64'h1);
        @(negedge clk);
        #5;
        chk(s_gnt[3*NM +: NM] == 2'b10, "R6 loser served next", 64'(s_gnt[3*NM +: NM]), 64'h2);
        @(negedge clk);
        #5;
        chk(s_gnt[3*NM +: NM] == 2'b01, "R6 turn returns", 64'(s_gnt[3*NM +: NM]), 64'h1);
        m_valid = '0;

        // lock held by the initiator the pointer does not favour
        @(negedge clk);
        s_ready = '0;
        m_valid = 2'b10;
        #5;
        chk(s_gnt[3*NM +: NM] == 2'b10, "R7 lone requester", 64'(s_gnt[3*NM +: NM]), 64'h2);
        @(negedge clk);
        m_valid = 2'b11;
        #5;
        chk(s_gnt[3*NM +: NM] == 2'b10, "R7 lock kept against pointer", 64'(s_gnt[3*NM +: NM]), 64'h2);
        s_ready[3] = 1'b1;
        #1;
        chk(m_ready == 2'b10, "R8 locked owner accepted", 64'(m_ready), 64'h2);
        @(negedge clk);
        m_valid = '0;

        // different targets in one cycle
        @(negedge clk);
        m_addr = {32'h2000_0000, 32'h5000_0000};
        m_valid = 2'b11;
        s_ready = '1;
        #5;
        chk(s_valid == 5'b01010, "R4 both targets selected", 64'(s_valid), 64'ha);
        chk(s_gnt[1*NM +: NM] == 2'b01 && s_gnt[3*NM +: NM] == 2'b10, "R4 owners",
            64'(s_gnt), 64'h84);
        chk(m_ready == 2'b11, "R4 both accepted", 64'(m_ready), 64'h3);
        chk(s_addr[3*AW +: AW] == 32'h2000_0000, "R4 address routed", 64'(s_addr[3*AW +: AW]), 64'h2000_0000);

        // miss on one initiator, hit on the other
        @(negedge clk);
        m_addr = {32'h4C00_0000, 32'h9000_0000};
        m_valid = 2'b11;
        #5;
        chk(s_valid == 5'b00100 && s_gnt[2*NM +: NM] == 2'b10, "R3 miss leaves other alone",
            64'(s_gnt), 64'h20);
        @(negedge clk);
        chk(m_decerr == 2'b01, "R3 error on missing initiator", 64'(m_decerr), 64'h1);
        m_valid = '0;
        @(negedge clk);
        chk(m_decerr == '0, "R3 error single cycle", 64'(m_decerr), 64'h0);

        finish_run();
    end

endmodule